// File: doc/BRIEF.md
# MOSI Coherence Line Controller

This block tracks the coherence state of one cache line in a directory-based MOSI system. It takes processor requests (read, write, replace) and network messages aimed at the line (invalidate, forwarded shared or exclusive requests, a writeback acknowledge, data). It answers with outgoing requests, acknowledges, writebacks and data. Between a miss or a writeback and its completion the line sits in a transient state. That state remembers any invalidation or forward that raced with the outstanding request, so that it can be honoured once the data lands.

A small payload register stands in for the line's data, so that read and write completion can be seen at the ports. While the controller cannot take a request, it holds the processor off with a combinational stall. A message that arrives where the protocol defines no reaction sets a sticky error flag. Outgoing traffic goes through a single holding slot with valid/ready flow control. Incoming messages are accepted only while that slot can take a new entry.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset the line reports state I, the data register holds zero, and no message, completion or error is raised. The `line_state` codes are I=0, S=1, O=2, M=3, IS=4, ISI=5, IM=6, IMI=7, IMO=8, IMOI=9, OI=10, MI=11, OM=12.
- R2: In I, the following apply:
  - A read sends GetS and enters IS.
  - A write latches its value and sends GetM and enters IM.
  - A replace completes at once with no message.
  - An invalidate is answered with Ack.
  - A late writeback acknowledge is absorbed without error.
- R3: In S, the following apply:
  - A read completes.
  - A write sends GetM and enters IM.
  - A replace drops silently to I.
  - An invalidate sends Ack and enters I.
- R4: In O, the following apply:
  - A read completes.
  - A write sends GetM and enters OM.
  - A replace sends a writeback and enters OI.
  - A forwarded GetS is answered with Data and the line stays in O.
  - A forwarded GetM is answered with Data and the line enters I.
- R5: In M, the following apply:
  - Reads complete.
  - Writes complete and update the data.
  - A replace sends a writeback and enters MI.
  - A forwarded GetS is answered with Data and the line enters O.
  - A forwarded GetM is answered with Data and the line enters I.
- R6: `cpu_stall` is high in every transient state, while an incoming message is offered, and while the outgoing slot is full and not draining. A stalled request has no effect.
- R7: In IS, an invalidate sends Ack and enters ISI. In IS, arriving data completes the read with the delivered value and enters S. In ISI, arriving data completes the read and enters I.
- R8: In IM, the following apply:
  - An invalidate is acknowledged and the line stays in IM.
  - A forwarded GetS enters IMO.
  - A forwarded GetM enters IMI.
  - Data performs the write and enters M.
- R9: In IMO, the following apply:
  - An invalidate sends Ack and enters IMI.
  - A forwarded GetM enters IMOI.
  - Data performs the write, sends Data and enters O.
  In IMI or IMOI, data performs the write, sends Data and enters I.
- R10: In OM, the following apply:
  - A forwarded GetS is answered with Data.
  - A forwarded GetM is answered with Data and the line falls back to IM.
  - Data performs the write and enters M.
  In OI or MI, the following apply:
  - A forwarded GetS is answered with Data.
  - A forwarded GetM is answered with Data and the line enters I.
  - A writeback acknowledge enters I.
- R11: Incoming codes are INV=0, FWD_GETS=1, FWD_GETM=2, PUTM_ACK=3, DATA=4. A message with no defined reaction in the current state is consumed, leaves the state unchanged, sends nothing, and sets `proto_err`. Codes 5 to 7 count as such messages. `proto_err` stays set until reset.
- R12: Outgoing codes are GETS=0, GETM=1, PUTM=2, ACK=3, DATA=4. Processor op codes are read=0, write=1, replace=2. At most one message leaves per cycle. A message waiting on `out_ready` keeps its type and data. `in_ready` is high only when the slot is empty or draining.
- R13: When an incoming message and a processor request arrive in the same cycle, the message is handled and the request is stalled.
- R14: `cpu_done` pulses for one cycle, one clock after a request or its data completes. `cpu_rdata` then shows the line value after the operation: the read value, the written value, or the held value on replace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | Request kind: read, write, replace |
| cpu_wdata | input | DATA_W | Write value |
| cpu_stall | output | 1 | Request cannot be taken this cycle |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | DATA_W | Line value at completion |
| in_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | Incoming message accepted |
| in_type | input | 3 | Incoming message code |
| in_data | input | DATA_W | Incoming payload |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Network takes the outgoing message |
| out_type | output | 3 | Outgoing message code |
| out_data | output | DATA_W | Outgoing payload |
| line_state | output | 4 | Current coherence state code |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The bench builds the block with its default 8-bit payload. Each write in the walk uses its own byte value, and each data message carries a value that differs from the pending write. A wrong data source is therefore visible in the completion value or in the outgoing Data payload. An 8-bit payload also gives enough distinct values to follow every transient path (IS, ISI, IM, IMI, IMO, IMOI, OM, OI, MI) end to end. Held back-pressure on the outgoing slot exposes the ready coupling between the two message ports.

// File: rtl/coh_line_pkg.sv
package coh_line_pkg;

    typedef enum logic [3:0] {
        ST_I    = 4'd0,
        ST_S    = 4'd1,
        ST_O    = 4'd2,
        ST_M    = 4'd3,
        ST_IS   = 4'd4,
        ST_ISI  = 4'd5,
        ST_IM   = 4'd6,
        ST_IMI  = 4'd7,
        ST_IMO  = 4'd8,
        ST_IMOI = 4'd9,
        ST_OI   = 4'd10,
        ST_MI   = 4'd11,
        ST_OM   = 4'd12
    } line_st_e;

    // incoming network codes
    localparam logic [2:0] IN_INV   = 3'd0;
    localparam logic [2:0] IN_FGETS = 3'd1;
    localparam logic [2:0] IN_FGETM = 3'd2;
    localparam logic [2:0] IN_PACK  = 3'd3;
    localparam logic [2:0] IN_DATA  = 3'd4;

    // outgoing network codes
    localparam logic [2:0] OUT_GETS = 3'd0;
    localparam logic [2:0] OUT_GETM = 3'd1;
    localparam logic [2:0] OUT_PUTM = 3'd2;
    localparam logic [2:0] OUT_ACK  = 3'd3;
    localparam logic [2:0] OUT_DATA = 3'd4;

    // processor ops
    localparam logic [1:0] OP_RD   = 2'd0;
    localparam logic [1:0] OP_WR   = 2'd1;
    localparam logic [1:0] OP_REPL = 2'd2;

    function automatic logic st_is_transient(input line_st_e s);
        return (s >= ST_IS);
    endfunction

endpackage

// File: rtl/coh_line_next.sv
module coh_line_next
    import coh_line_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  line_st_e          cur_st,
    input  logic [DATA_W-1:0] cur_data,
    input  logic [DATA_W-1:0] cur_pend,
    input  logic              net_go,
    input  logic [2:0]        net_type,
    input  logic [DATA_W-1:0] net_data,
    input  logic              cpu_go,
    input  logic [1:0]        cpu_op,
    input  logic [DATA_W-1:0] cpu_wdata,
    output line_st_e          nx_st,
    output logic [DATA_W-1:0] nx_data,
    output logic [DATA_W-1:0] nx_pend,
    output logic              nx_send,
    output logic [2:0]        nx_send_type,
    output logic [DATA_W-1:0] nx_send_data,
    output logic              nx_done,
    output logic              nx_bad
);

    always_comb begin
        nx_st        = cur_st;
        nx_data      = cur_data;
        nx_pend      = cur_pend;
        nx_send      = 1'b0;
        nx_send_type = OUT_ACK;
        nx_send_data = '0;
        nx_done      = 1'b0;
        nx_bad       = 1'b0;

        if (net_go) begin
            case (cur_st)
                ST_I: begin
                    if (net_type == IN_INV) begin
                        nx_send = 1'b1;
                        nx_send_type = OUT_ACK;
                    end else if (net_type != IN_PACK) begin
                        nx_bad = 1'b1;
                    end
                end
                ST_S: begin
                    if (net_type == IN_INV) begin
                        nx_send = 1'b1;
                        nx_send_type = OUT_ACK;
                        nx_st = ST_I;
                    end else begin
                        nx_bad = 1'b1;
                    end
                end
                ST_O, ST_M: begin
                    if (net_type == IN_FGETS) begin
                        nx_send = 1'b1;
                        nx_send_type = OUT_DATA;
                        nx_send_data = cur_data;
                        nx_st = ST_O;
                    end else if (net_type == IN_FGETM) begin
                        nx_send = 1'b1;
                        nx_send_type = OUT_DATA;
                        nx_send_data = cur_data;
                        nx_st = ST_I;
                    end else begin
                        nx_bad = 1'b1;
                    end
                end
                ST_IS, ST_ISI: begin
                    if (net_type == IN_INV && cur_st == ST_IS) begin
                        nx_send = 1'b1;
                        nx_send_type = OUT_ACK;
                        nx_st = ST_ISI;
                    end else if (net_type == IN_DATA) begin
                        nx_data = net_data;
                        nx_done = 1'b1;
                        nx_st = (cur_st == ST_IS) ? ST_S : ST_I;
                    end else begin
                        nx_bad = 1'b1;
                    end
                end
                ST_IM: begin
                    case (net_type)
                        IN_INV: begin
                            nx_send = 1'b1;
                            nx_send_type = OUT_ACK;
                        end
                        IN_FGETS: nx_st = ST_IMO;
                        IN_FGETM: nx_st = ST_IMI;
                        IN_DATA: begin
                            nx_data = cur_pend;
                            nx_done = 1'b1;
                            nx_st = ST_M;
                        end
                        default: nx_bad = 1'b1;
                    endcase
                end
                ST_IMO: begin
                    case (net_type)
                        IN_INV: begin
                            nx_send = 1'b1;
                            nx_send_type = OUT_ACK;
                            nx_st = ST_IMI;
                        end
                        IN_FGETM: nx_st = ST_IMOI;
                        IN_DATA: begin
                            nx_data = cur_pend;
                            nx_done = 1'b1;
                            nx_send = 1'b1;
                            nx_send_type = OUT_DATA;
                            nx_send_data = cur_pend;
                            nx_st = ST_O;
                        end
                        default: nx_bad = 1'b1;
                    endcase
                end
                ST_IMI, ST_IMOI: begin
                    if (net_type == IN_DATA) begin
                        nx_data = cur_pend;
                        nx_done = 1'b1;
                        nx_send = 1'b1;
                        nx_send_type = OUT_DATA;
                        nx_send_data = cur_pend;
                        nx_st = ST_I;
                    end else begin
                        nx_bad = 1'b1;
                    end
                end
                ST_OI, ST_MI: begin
                    case (net_type)
                        IN_FGETS: begin
                            nx_send = 1'b1;
                            nx_send_type = OUT_DATA;
                            nx_send_data = cur_data;
                        end
                        IN_FGETM: begin
                            nx_send = 1'b1;
                            nx_send_type = OUT_DATA;
                            nx_send_data = cur_data;
                            nx_st = ST_I;
                        end
                        IN_PACK: nx_st = ST_I;
                        default: nx_bad = 1'b1;
                    endcase
                end
                ST_OM: begin
                    case (net_type)
                        IN_FGETS: begin
                            nx_send = 1'b1;
                            nx_send_type = OUT_DATA;
                            nx_send_data = cur_data;
                        end
                        IN_FGETM: begin
                            nx_send = 1'b1;
                            nx_send_type = OUT_DATA;
                            nx_send_data = cur_data;
                            nx_st = ST_IM;
                        end
                        IN_DATA: begin
                            nx_data = cur_pend;
                            nx_done = 1'b1;
                            nx_st = ST_M;
                        end
                        default: nx_bad = 1'b1;
                    endcase
                end
                default: nx_bad = 1'b1;
            endcase
        end else if (cpu_go) begin
            case (cur_st)
                ST_I: begin
                    case (cpu_op)
                        OP_RD: begin
                            nx_send = 1'b1;
                            nx_send_type = OUT_GETS;
                            nx_st = ST_IS;
                        end
                        OP_WR: begin
                            nx_pend = cpu_wdata;
                            nx_send = 1'b1;
                            nx_send_type = OUT_GETM;
                            nx_st = ST_IM;
                        end
                        default: nx_done = 1'b1;
                    endcase
                end
                ST_S: begin
                    case (cpu_op)
                        OP_WR: begin
                            nx_pend = cpu_wdata;
                            nx_send = 1'b1;
                            nx_send_type = OUT_GETM;
                            nx_st = ST_IM;
                        end
                        OP_REPL: begin
                            nx_done = 1'b1;
                            nx_st = ST_I;
                        end
                        default: nx_done = 1'b1;
                    endcase
                end
                ST_O, ST_M: begin
                    case (cpu_op)
                        OP_WR: begin
                            if (cur_st == ST_M) begin
                                nx_data = cpu_wdata;
                                nx_done = 1'b1;
                            end else begin
                                nx_pend = cpu_wdata;
                                nx_send = 1'b1;
                                nx_send_type = OUT_GETM;
                                nx_st = ST_OM;
                            end
                        end
                        OP_REPL: begin
                            nx_done = 1'b1;
                            nx_send = 1'b1;
                            nx_send_type = OUT_PUTM;
                            nx_send_data = cur_data;
                            nx_st = (cur_st == ST_M) ? ST_MI : ST_OI;
                        end
                        default: nx_done = 1'b1;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/coh_msg_slot.sv
module coh_msg_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [2:0]        push_type,
    input  logic [DATA_W-1:0] push_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [2:0]        out_type,
    output logic [DATA_W-1:0] out_data,
    output logic              slot_free
);

    typedef struct packed {
        logic              vld;
        logic [2:0]        kind;
        logic [DATA_W-1:0] pay;
    } slot_t;

    slot_t slot_d, slot_q;

    assign slot_free = !slot_q.vld || out_ready;
    assign out_valid = slot_q.vld;
    assign out_type  = slot_q.kind;
    assign out_data  = slot_q.pay;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.vld && out_ready) begin
            slot_d.vld = 1'b0;
        end
        if (push) begin
            slot_d.vld  = 1'b1;
            slot_d.kind = push_type;
            slot_d.pay  = push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    // R12: a waiting message keeps its contents
    p_out_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_type) && $stable(out_data)));

    // R12: nothing is pushed into an occupied slot
    p_push_free_r12: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> slot_free);

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_line_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_stall,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_type,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_type,
    output logic [DATA_W-1:0] out_data,
    output logic [3:0]        line_state,
    output logic              proto_err
);

    typedef struct packed {
        line_st_e          st;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] pend;
        logic              done;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              slot_free;
    logic              net_go;
    logic              cpu_go;
    line_st_e          nx_st;
    logic [DATA_W-1:0] nx_data;
    logic [DATA_W-1:0] nx_pend;
    logic              nx_send;
    logic [2:0]        nx_send_type;
    logic [DATA_W-1:0] nx_send_data;
    logic              nx_done;
    logic              nx_bad;

    assign in_ready  = slot_free;
    assign net_go    = in_valid && slot_free;
    assign cpu_stall = st_is_transient(regs_q.st) || in_valid || !slot_free;
    assign cpu_go    = cpu_valid && !cpu_stall;

    coh_line_next #(.DATA_W(DATA_W)) u_next (
        .cur_st       (regs_q.st),
        .cur_data     (regs_q.data),
        .cur_pend     (regs_q.pend),
        .net_go       (net_go),
        .net_type     (in_type),
        .net_data     (in_data),
        .cpu_go       (cpu_go),
        .cpu_op       (cpu_op),
        .cpu_wdata    (cpu_wdata),
        .nx_st        (nx_st),
        .nx_data      (nx_data),
        .nx_pend      (nx_pend),
        .nx_send      (nx_send),
        .nx_send_type (nx_send_type),
        .nx_send_data (nx_send_data),
        .nx_done      (nx_done),
        .nx_bad       (nx_bad)
    );

    coh_msg_slot #(.DATA_W(DATA_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (nx_send),
        .push_type (nx_send_type),
        .push_data (nx_send_data),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_type  (out_type),
        .out_data  (out_data),
        .slot_free (slot_free)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.st   = nx_st;
        regs_d.data = nx_data;
        regs_d.pend = nx_pend;
        regs_d.done = nx_done;
        if (nx_done) begin
            regs_d.rdata = nx_data;
        end
        regs_d.err  = regs_q.err || (net_go && nx_bad);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_I, default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cpu_done   = regs_q.done;
    assign cpu_rdata  = regs_q.rdata;
    assign line_state = regs_q.st;
    assign proto_err  = regs_q.err;

    // R2: entering IS from I always leaves a GetS in the slot
    p_gets_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_IS && $past(regs_q.st) == ST_I) |-> (out_valid && out_type == OUT_GETS));

    // R11: an undefined message leaves the state alone
    p_bad_keeps_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (net_go && nx_bad) |=> $stable(regs_q.st));

    // R11: error flag is sticky
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R12: incoming port is closed only while a message waits
    p_in_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);

endmodule

// File: tb/coh_line_ctrl_test.sv
`timescale 1ns/1ps
module coh_line_ctrl_test;

    localparam int DW = 8;

    typedef struct packed {
        logic       net;
        logic [2:0] code;
        logic [7:0] dat;
        logic [3:0] st;
        logic       ov;
        logic [2:0] ot;
        logic [7:0] od;
        logic       dn;
        logic [7:0] rd;
        logic [3:0] req;
    } step_t;

    localparam logic N = 1'b1, C = 1'b0;
    localparam logic [2:0] INV = 3'd0, FGS = 3'd1, FGM = 3'd2, PAK = 3'd3, DAT = 3'd4;
    localparam logic [2:0] RD = 3'd0, WR = 3'd1, RP = 3'd2;
    localparam logic [2:0] GS = 3'd0, GM = 3'd1, PM = 3'd2, AK = 3'd3, DT = 3'd4;
    localparam int NSTEP = 56;

    // R2 R3 R4 R5 R7 R8 R9 R10 R14 walked through the protocol
    localparam step_t TBL [0:NSTEP-1] = '{
        '{C, RD,  8'h00, 4'd4,  1'b1, GS, 8'h00, 1'b0, 8'h00, 4'd2},
        '{N, DAT, 8'h5A, 4'd1,  1'b0, GS, 8'h00, 1'b1, 8'h5A, 4'd7},
        '{C, RD,  8'h00, 4'd1,  1'b0, GS, 8'h00, 1'b1, 8'h5A, 4'd3},
        '{C, WR,  8'h11, 4'd6,  1'b1, GM, 8'h00, 1'b0, 8'h00, 4'd3},
        '{N, INV, 8'h00, 4'd6,  1'b1, AK, 8'h00, 1'b0, 8'h00, 4'd8},
        '{N, DAT, 8'h77, 4'd3,  1'b0, GS, 8'h00, 1'b1, 8'h11, 4'd8},
        '{C, RD,  8'h00, 4'd3,  1'b0, GS, 8'h00, 1'b1, 8'h11, 4'd5},
        '{C, WR,  8'h22, 4'd3,  1'b0, GS, 8'h00, 1'b1, 8'h22, 4'd5},
        '{N, FGS, 8'h00, 4'd2,  1'b1, DT, 8'h22, 1'b0, 8'h00, 4'd5},
        '{C, RD,  8'h00, 4'd2,  1'b0, GS, 8'h00, 1'b1, 8'h22, 4'd4},
        '{N, FGS, 8'h00, 4'd2,  1'b1, DT, 8'h22, 1'b0, 8'h00, 4'd4},
        '{C, WR,  8'h33, 4'd12, 1'b1, GM, 8'h00, 1'b0, 8'h00, 4'd4},
        '{N, FGS, 8'h00, 4'd12, 1'b1, DT, 8'h22, 1'b0, 8'h00, 4'd10},
        '{N, DAT, 8'h99, 4'd3,  1'b0, GS, 8'h00, 1'b1, 8'h33, 4'd10},
        '{C, RP,  8'h00, 4'd11, 1'b1, PM, 8'h33, 1'b1, 8'h33, 4'd5},
        '{N, PAK, 8'h00, 4'd0,  1'b0, GS, 8'h00, 1'b0, 8'h00, 4'd10},
        '{C, WR,  8'h44, 4'd6,  1'b1, GM, 8'h00, 1'b0, 8'h00, 4'd2},
        '{N, FGS, 8'h00, 4'd8,  1'b0, GS, 8'h00, 1'b0, 8'h00, 4'd8},
        '{N, INV, 8'h00, 4'd7,  1'b1, AK, 8'h00, 1'b0, 8'h00, 4'd9},
        '{N, DAT, 8'h10, 4'd0,  1'b1, DT, 8'h44, 1'b1, 8'h44, 4'd9},
        '{C, WR,  8'h55, 4'd6,  1'b1, GM, 8'h00, 1'b0, 8'h00, 4'd2},
        '{N, FGS, 8'h00, 4'd8,  1'b0, GS, 8'h00, 1'b0, 8'h00, 4'd8},
        '{N, FGM, 8'h00, 4'd9,  1'b0, GS, 8'h00, 1'b0, 8'h00, 4'd9},
        '{N, DAT, 8'h01, 4'd0,  1'b1, DT, 8'h55, 1'b1, 8'h55, 4'd9},
        '{C, WR,  8'h66, 4'd6,  1'b1, GM, 8'h00, 1'b0, 8'h00, 4'd2},
        '{N, FGS, 8'h00, 4'd8,  1'b0, GS, 8'h00, 1'b0, 8'h00, 4'd8},
        '{N, DAT, 8'h02, 4'd2,  1'b1, DT, 8'h66, 1'b1, 8'h66, 4'd9},
        '{N, FGM, 8'h00, 4'd0,  1'b1, DT, 8'h66, 1'b0, 8'h00, 4'd4},
        '{C, RD,  8'h00, 4'd4,  1'b1, GS, 8'h00, 1'b0, 8'h00, 4'd2},
        '{N, INV, 8'h00, 4'd5,  1'b1, AK, 8'h00, 1'b0, 8'h00, 4'd7},
        '{N, DAT, 8'h3C, 4'd0,  1'b0, GS, 8'h00, 1'b1, 8'h3C, 4'd7},
        '{C, WR,  8'h70, 4'd6,  1'b1, GM, 8'h00, 1'b0, 8'h00, 4'd2},
        '{N, DAT, 8'h00, 4'd3,  1'b0, GS, 8'h00, 1'b1, 8'h70, 4'd8},
        '{N, FGM, 8'h00, 4'd0,  1'b1, DT, 8'h70, 1'b0, 8'h00, 4'd5},
        '{C, WR,  8'h80, 4'd6,  1'b1, GM, 8'h00, 1'b0, 8'h00, 4'd2},
        '{N, DAT, 8'h00, 4'd3,  1'b0, GS, 8'h00, 1'b1, 8'h80, 4'd8},
        '{C, RP,  8'h00, 4'd11, 1'b1, PM, 8'h80, 1'b1, 8'h80, 4'd5},
        '{N, FGS, 8'h00, 4'd11, 1'b1, DT, 8'h80, 1'b0, 8'h00, 4'd10},
        '{N, FGM, 8'h00, 4'd0,  1'b1, DT, 8'h80, 1'b0, 8'h00, 4'd10},
        '{N, PAK, 8'h00, 4'd0,  1'b0, GS, 8'h00, 1'b0, 8'h00, 4'd2},
        '{C, WR,  8'h90, 4'd6,  1'b1, GM, 8'h00, 1'b0, 8'h00, 4'd2},
        '{N, FGM, 8'h00, 4'd7,  1'b0, GS, 8'h00, 1'b0, 8'h00, 4'd8},
        '{N, DAT, 8'h00, 4'd0,  1'b1, DT, 8'h90, 1'b1, 8'h90, 4'd9},
        '{C, WR,  8'hA0, 4'd6,  1'b1, GM, 8'h00, 1'b0, 8'h00, 4'd2},
        '{N, DAT, 8'h00, 4'd3,  1'b0, GS, 8'h00, 1'b1, 8'hA0, 4'd8},
        '{N, FGS, 8'h00, 4'd2,  1'b1, DT, 8'hA0, 1'b0, 8'h00, 4'd5},
        '{C, RP,  8'h00, 4'd10, 1'b1, PM, 8'hA0, 1'b1, 8'hA0, 4'd4},
        '{N, PAK, 8'h00, 4'd0,  1'b0, GS, 8'h00, 1'b0, 8'h00, 4'd10},
        '{C, RD,  8'h00, 4'd4,  1'b1, GS, 8'h00, 1'b0, 8'h00, 4'd2},
        '{N, DAT, 8'hB1, 4'd1,  1'b0, GS, 8'h00, 1'b1, 8'hB1, 4'd7},
        '{C, RP,  8'h00, 4'd0,  1'b0, GS, 8'h00, 1'b1, 8'hB1, 4'd3},
        '{N, INV, 8'h00, 4'd0,  1'b1, AK, 8'h00, 1'b0, 8'h00, 4'd2},
        '{C, RP,  8'h00, 4'd0,  1'b0, GS, 8'h00, 1'b1, 8'hB1, 4'd2},
        '{C, RD,  8'h00, 4'd4,  1'b1, GS, 8'h00, 1'b0, 8'h00, 4'd2},
        '{N, DAT, 8'hC2, 4'd1,  1'b0, GS, 8'h00, 1'b1, 8'hC2, 4'd7},
        '{N, INV, 8'h00, 4'd0,  1'b1, AK, 8'h00, 1'b0, 8'h00, 4'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_valid;
    logic [1:0]    cpu_op;
    logic [DW-1:0] cpu_wdata;
    logic          cpu_stall;
    logic          cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          in_valid;
    logic          in_ready;
    logic [2:0]    in_type;
    logic [DW-1:0] in_data;
    logic          out_valid;
    logic          out_ready;
    logic [2:0]    out_type;
    logic [DW-1:0] out_data;
    logic [3:0]    line_state;
    logic          proto_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    coh_line_ctrl #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_wdata(cpu_wdata),
        .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type), .out_data(out_data),
        .line_state(line_state), .proto_err(proto_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_valid = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        cpu_op = '0; cpu_wdata = '0; in_type = '0; in_data = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_step(input step_t s, input int idx);
        string tg;
        tg = $sformatf("R%0d step%0d", s.req, idx);
        if (s.net) begin
            in_valid = 1'b1; in_type = s.code; in_data = s.dat;
        end else begin
            cpu_valid = 1'b1; cpu_op = s.code[1:0]; cpu_wdata = s.dat;
        end
        @(negedge clk);
        in_valid = 1'b0; cpu_valid = 1'b0;
        chk({tg, " state"}, 32'(line_state), 32'(s.st));
        chk({tg, " out_valid"}, 32'(out_valid), 32'(s.ov));
        if (s.ov) begin
            chk({tg, " out_type"}, 32'(out_type), 32'(s.ot));
            chk({tg, " out_data"}, 32'(out_data), 32'(s.od));
        end
        chk({tg, " done"}, 32'(cpu_done), 32'(s.dn));
        if (s.dn) chk({tg, " rdata"}, 32'(cpu_rdata), 32'(s.rd));
        chk({tg, " err"}, 32'(proto_err), 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cpu_valid = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        cpu_op = '0; cpu_wdata = '0; in_type = '0; in_data = '0;
        do_reset();

        // R1 reset state
        @(negedge clk);
        chk("R1 state", 32'(line_state), 32'd0);
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 done", 32'(cpu_done), 32'd0);
        chk("R1 err", 32'(proto_err), 32'd0);
        chk("R1 stall", 32'(cpu_stall), 32'd0);
        chk("R1 in_ready", 32'(in_ready), 32'd1);

        for (int i = 0; i < NSTEP; i++) begin
            run_step(TBL[i], i);
        end

        // R13 priority: line in S, read and invalidate together
        run_step('{C, RD, 8'h00, 4'd4, 1'b1, GS, 8'h00, 1'b0, 8'h00, 4'd2}, 100);
        run_step('{N, DAT, 8'h4D, 4'd1, 1'b0, GS, 8'h00, 1'b1, 8'h4D, 4'd7}, 101);
        cpu_valid = 1'b1; cpu_op = RD[1:0];
        in_valid = 1'b1; in_type = INV;
        @(negedge clk);
        chk("R13 state after race", 32'(line_state), 32'd0);
        chk("R13 ack sent", 32'(out_type), 32'(AK));
        chk("R13 no done", 32'(cpu_done), 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R13 held read issues GetS", 32'(out_type), 32'(GS));
        chk("R13 state IS", 32'(line_state), 32'd4);
        cpu_valid = 1'b0;

        // R6 stall in IS: a held write has no effect
        chk("R6 stall in IS", 32'(cpu_stall), 32'd1);
        cpu_valid = 1'b1; cpu_op = WR[1:0]; cpu_wdata = 8'hEE;
        @(negedge clk);
        @(negedge clk);
        chk("R6 no message", 32'(out_valid), 32'd0);
        chk("R6 state kept", 32'(line_state), 32'd4);
        chk("R6 no done", 32'(cpu_done), 32'd0);
        cpu_valid = 1'b0;
        run_step('{N, DAT, 8'h6B, 4'd1, 1'b0, GS, 8'h00, 1'b1, 8'h6B, 4'd7}, 102);

        // R12 back-pressure on the outgoing slot
        out_ready = 1'b0;
        cpu_valid = 1'b1; cpu_op = WR[1:0]; cpu_wdata = 8'hC7;
        @(negedge clk);
        cpu_valid = 1'b0;
        chk("R12 GetM queued", 32'(out_type), 32'(GM));
        chk("R12 state IM", 32'(line_state), 32'd6);
        chk("R12 in_ready low", 32'(in_ready), 32'd0);
        in_valid = 1'b1; in_type = INV;
        @(negedge clk);
        chk("R12 GetM still held", 32'({out_valid, out_type}), 32'({1'b1, GM}));
        chk("R12 state unchanged", 32'(line_state), 32'd6);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12 ack after drain", 32'({out_valid, out_type}), 32'({1'b1, AK}));
        run_step('{N, DAT, 8'h00, 4'd3, 1'b0, GS, 8'h00, 1'b1, 8'hC7, 4'd8}, 103);

        // R11 undefined messages
        do_reset();
        in_valid = 1'b1; in_type = FGS;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 err set", 32'(proto_err), 32'd1);
        chk("R11 state kept", 32'(line_state), 32'd0);
        chk("R11 nothing sent", 32'(out_valid), 32'd0);
        in_valid = 1'b1; in_type = 3'd7;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R11 err sticky", 32'(proto_err), 32'd1);
        chk("R11 state kept code7", 32'(line_state), 32'd0);
        do_reset();
        @(negedge clk);
        chk("R1 err cleared by reset", 32'(proto_err), 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule